// File: doc/BRIEF.md
# Command Channel Engine for a Power-Management Serial Bus

This block is one software-visible command channel that sits in front of a serial power-management bus. Software loads up to eight bytes of payload into two 32-bit payload registers and then writes a single command word. The engine decodes that word into a transaction descriptor and presents it on a bus-side request port. The descriptor holds an extended opcode, a read flag, the slave ID, the register address, the byte count minus one and the payload.

The descriptor is held steady until the bus side answers with a two-bit result code and, for reads, up to eight bytes of returned data. The engine then posts a four-bit completion status. After a successful read it also fills two read-data registers. Control commands (reset, sleep, shutdown, wakeup) are forwarded with the slave ID only. Unknown opcodes are refused on the spot. A command that arrives while a transaction is outstanding is discarded and flagged in the next completion status.

Top module: `cmd_channel_engine`

## Requirements
- R1: After reset, status (0x08), the read-data registers (0x18, 0x1C), the config register (0x04) and req_valid are all zero.
- R2: A command word written to offset 0x00 is decoded as opcode [31:27], slave ID [23:20], address [19:4] and byte-count-minus-one [2:0]. The descriptor appears on the request port with req_valid high from the clock edge after the write, and stays unchanged until the edge on which rsp_valid is sampled.
- R3: Payload byte k (k = 0..7) is taken from offset 0x10 for k < 4 and from 0x14 for k >= 4, least significant byte first, and is driven on req_wdata[8k+7:8k]. Bytes above the byte count are driven as zero. The payload is captured when the command is accepted, so later payload-register writes leave an outstanding transaction untouched.
- R4: Opcodes 1, 13 and 15 are reads (req_read = 1, req_wdata = 0). Opcodes 0, 2, 14 and 16 are writes (req_read = 0). For both kinds req_xop is the opcode zero-extended to 7 bits.
- R5: Opcodes 3, 4, 5 and 6 are control commands: req_xop = 0x40 | opcode, and the slave ID is passed on. req_addr, req_bcm1 and req_wdata are zero whatever the command word holds, and req_read = 0.
- R6: Any other opcode raises no request, and the status becomes 0x3 (done and failure) on the edge after the write.
- R7: Accepting a command clears the status to zero until completion. On completion, status bit 0 (done) is set, bit 1 reflects rsp_code 1 (failure), bit 2 reflects rsp_code 2 (denied) and bit 3 reflects rsp_code 3 (dropped). rsp_code 0 means success.
- R8: A command written while a transaction is outstanding, including the cycle in which rsp_valid arrives, is discarded. It changes neither the descriptor nor req_valid, and it sets status bit 3 at completion.
- R9: On a successful read (rsp_code 0), offset 0x18 receives returned bytes 0-3 and 0x1C receives bytes 4-7, least significant byte first. Bytes beyond the byte count read as zero.
- R10: The read-data registers are left unchanged by writes, by control commands and by reads that complete with a non-zero rsp_code.
- R11: The config register at 0x04 and the payload registers read back what was written. Offset 0x00 reads back the last command written while idle. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| req_valid | output | 1 | Transaction outstanding on the bus side |
| req_xop | output | 7 | Extended bus opcode |
| req_read | output | 1 | Transaction returns data |
| req_sid | output | 4 | Slave ID |
| req_addr | output | 16 | Slave register address |
| req_bcm1 | output | 3 | Byte count minus one |
| req_wdata | output | 64 | Payload, byte k at [8k+7:8k] |
| rsp_valid | input | 1 | Bus-side completion strobe |
| rsp_code | input | 2 | 0 ok, 1 failure, 2 denied, 3 dropped |
| rsp_rdata | input | 64 | Returned read bytes, byte k at [8k+7:8k] |

## Verification
A new command write and the bus-side completion can land on the same clock edge. The engine must treat that edge as still busy: the new command is discarded, and its drop is folded into the status word posted at that very edge. The bench provokes this by having its responder raise a command write in the same cycle it raises rsp_valid. It then judges the result from the posted status (done plus dropped) and from req_valid staying low afterwards, with the scoreboard queue empty so that any stray launch is caught as an unexpected request. A second case places the discarded command mid-flight and follows it with a payload write, and the scoreboard confirms that the outstanding descriptor is unchanged.

// File: rtl/cce_pkg.sv
package cce_pkg;

  // command word field positions (fixed layout decoded by software)
  localparam int OPC_LSB = 27;
  localparam int OPC_W   = 5;
  localparam int SID_LSB = 20;
  localparam int SID_W   = 4;
  localparam int ADR_LSB = 4;
  localparam int ADR_W   = 16;
  localparam int BCM_LSB = 0;
  localparam int LANES   = 8;
  localparam int BCM_W   = $clog2(LANES);
  localparam int DATA_W  = LANES * 8;
  localparam int XOP_W   = 7;
  localparam int STS_W   = 4;

  localparam logic [1:0] RC_OK   = 2'd0;
  localparam logic [1:0] RC_FAIL = 2'd1;
  localparam logic [1:0] RC_DENY = 2'd2;
  localparam logic [1:0] RC_DROP = 2'd3;

  typedef enum logic [1:0] {
    KIND_WRITE,
    KIND_READ,
    KIND_CTRL,
    KIND_BAD
  } kind_e;

  typedef struct packed {
    logic [XOP_W-1:0]  xop;
    logic              is_read;
    logic [SID_W-1:0]  sid;
    logic [ADR_W-1:0]  addr;
    logic [BCM_W-1:0]  bcm1;
    logic [DATA_W-1:0] wdata;
  } desc_t;

  function automatic kind_e classify(input logic [OPC_W-1:0] opc);
    case (opc)
      5'd0, 5'd2, 5'd14, 5'd16: classify = KIND_WRITE;
      5'd1, 5'd13, 5'd15:       classify = KIND_READ;
      5'd3, 5'd4, 5'd5, 5'd6:   classify = KIND_CTRL;
      default:                  classify = KIND_BAD;
    endcase
  endfunction

  function automatic logic [XOP_W-1:0] ext_opcode(input logic [OPC_W-1:0] opc);
    logic [XOP_W-1:0] base;
    base = XOP_W'(opc);
    if (classify(opc) == KIND_CTRL) ext_opcode = base | 7'h40;
    else                            ext_opcode = base;
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [BCM_W-1:0] bcm1);
    for (int i = 0; i < LANES; i++) lane_mask[i] = (BCM_W'(i) <= bcm1);
  endfunction

  function automatic logic [DATA_W-1:0] byte_expand(input logic [LANES-1:0] m);
    for (int i = 0; i < LANES; i++) byte_expand[i*8 +: 8] = {8{m[i]}};
  endfunction

  function automatic logic [STS_W-1:0] status_word(input logic [1:0] code, input logic drop);
    status_word[0] = 1'b1;
    status_word[1] = (code == RC_FAIL);
    status_word[2] = (code == RC_DENY);
    status_word[3] = (code == RC_DROP) || drop;
  endfunction

endpackage

// File: rtl/cce_decode.sv
module cce_decode
  import cce_pkg::*;
(
  input  logic [OPC_W-1:0]  opc_i,
  input  logic [SID_W-1:0]  sid_i,
  input  logic [ADR_W-1:0]  addr_i,
  input  logic [BCM_W-1:0]  bcm1_i,
  input  logic [DATA_W-1:0] payload_i,
  output kind_e             kind_o,
  output desc_t             desc_o
);

  logic [DATA_W-1:0] keep_bits;
  assign keep_bits = byte_expand(lane_mask(bcm1_i));

  always_comb begin
    kind_o     = classify(opc_i);
    desc_o     = '0;
    desc_o.xop = ext_opcode(opc_i);
    desc_o.sid = sid_i;
    case (kind_o)
      KIND_WRITE: begin
        desc_o.addr  = addr_i;
        desc_o.bcm1  = bcm1_i;
        desc_o.wdata = payload_i & keep_bits;
      end
      KIND_READ: begin
        desc_o.addr    = addr_i;
        desc_o.bcm1    = bcm1_i;
        desc_o.is_read = 1'b1;
      end
      default: begin
        // control and refused commands carry no address, count or payload
      end
    endcase
  end

endmodule

// File: rtl/cce_sequencer.sv
module cce_sequencer
  import cce_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  kind_e            kind_i,
  input  desc_t            desc_i,
  input  logic             rsp_valid,
  input  logic [1:0]       rsp_code,
  output logic             busy_o,
  output desc_t            desc_o,
  output logic [STS_W-1:0] status_o,
  output logic             finish_o
);

  logic  busy_q;
  logic  drop_pend_q;
  logic  [STS_W-1:0] status_q;
  desc_t desc_q;

  // named events for the checks below
  logic launch_evt;
  logic refuse_evt;
  logic collide_evt;
  logic finish_evt;

  assign launch_evt  = cmd_we && !busy_q && (kind_i != KIND_BAD);
  assign refuse_evt  = cmd_we && !busy_q && (kind_i == KIND_BAD);
  assign collide_evt = cmd_we && busy_q;
  assign finish_evt  = busy_q && rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      drop_pend_q <= 1'b0;
      status_q    <= '0;
      desc_q      <= '0;
    end else if (finish_evt) begin
      busy_q      <= 1'b0;
      drop_pend_q <= 1'b0;
      status_q    <= status_word(rsp_code, drop_pend_q || collide_evt);
    end else if (collide_evt) begin
      drop_pend_q <= 1'b1;
    end else if (launch_evt) begin
      busy_q      <= 1'b1;
      drop_pend_q <= 1'b0;
      status_q    <= '0;
      desc_q      <= desc_i;
    end else if (refuse_evt) begin
      status_q    <= 4'b0011;
    end
  end

  assign busy_o   = busy_q;
  assign desc_o   = desc_q;
  assign status_o = status_q;
  assign finish_o = finish_evt;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rsp_valid) |=> (busy_o && $stable(desc_o)));  // R2

  AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    launch_evt |=> (busy_o && status_o == '0));  // R7

  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> (!busy_o && status_o[0]));  // R7

  AST_REFUSE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_evt |=> (!busy_o && status_o == 4'b0011));  // R6

  AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (collide_evt && !rsp_valid) |=> (busy_o && $stable(desc_o)));  // R8

  AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (collide_evt && rsp_valid) |=> (!busy_o && status_o[3]));  // R8

endmodule

// File: rtl/cce_rd_capture.sv
module cce_rd_capture
  import cce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [BCM_W-1:0]  bcm1_i,
  input  logic [DATA_W-1:0] rsp_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_q;
    logic       lane_used;
    assign lane_used = (BCM_W'(l) <= bcm1_i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lane_q <= '0;
      else if (capture_i) lane_q <= lane_used ? rsp_rdata_i[l*8 +: 8] : 8'h00;
    end
    assign rdata_o[l*8 +: 8] = lane_q;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(rdata_o));  // R10

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> ((rdata_o & ~byte_expand(lane_mask($past(bcm1_i)))) == '0));  // R9

endmodule

// File: rtl/cmd_channel_engine.sv
module cmd_channel_engine
  import cce_pkg::*;
#(
  parameter int REG_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              req_valid,
  output logic [6:0]        req_xop,
  output logic              req_read,
  output logic [3:0]        req_sid,
  output logic [15:0]       req_addr,
  output logic [2:0]        req_bcm1,
  output logic [63:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [1:0]        rsp_code,
  input  logic [63:0]       rsp_rdata
);

  localparam int WORDS = DATA_W / 32;
  localparam logic [REG_AW-1:0] A_CMD = REG_AW'(8'h00);
  localparam logic [REG_AW-1:0] A_CFG = REG_AW'(8'h04);
  localparam logic [REG_AW-1:0] A_STS = REG_AW'(8'h08);
  localparam logic [REG_AW-1:0] A_WD0 = REG_AW'(8'h10);
  localparam logic [REG_AW-1:0] A_RD0 = REG_AW'(8'h18);

  logic [31:0]       cmd_q;
  logic [31:0]       cfg_q;
  logic [DATA_W-1:0] payload_q;
  logic [DATA_W-1:0] rdata_w;
  logic [STS_W-1:0]  status_w;
  logic              busy_w;
  logic              finish_w;
  logic              cmd_we;
  logic              capture_w;
  kind_e             kind_w;
  desc_t             desc_new;
  desc_t             desc_out;

  assign cmd_we = reg_we && (reg_addr == A_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      cfg_q     <= '0;
      payload_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_CMD && !busy_w) cmd_q <= reg_wdata;
      if (reg_addr == A_CFG) cfg_q <= reg_wdata;
      for (int w = 0; w < WORDS; w++)
        if (reg_addr == A_WD0 + REG_AW'(4*w)) payload_q[w*32 +: 32] <= reg_wdata;
    end
  end

  cce_decode u_decode (
    .opc_i     (reg_wdata[OPC_LSB +: OPC_W]),
    .sid_i     (reg_wdata[SID_LSB +: SID_W]),
    .addr_i    (reg_wdata[ADR_LSB +: ADR_W]),
    .bcm1_i    (reg_wdata[BCM_LSB +: BCM_W]),
    .payload_i (payload_q),
    .kind_o    (kind_w),
    .desc_o    (desc_new)
  );

  cce_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .kind_i    (kind_w),
    .desc_i    (desc_new),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .busy_o    (busy_w),
    .desc_o    (desc_out),
    .status_o  (status_w),
    .finish_o  (finish_w)
  );

  assign capture_w = finish_w && desc_out.is_read && (rsp_code == RC_OK);

  cce_rd_capture u_rdcap (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture_i   (capture_w),
    .bcm1_i      (desc_out.bcm1),
    .rsp_rdata_i (rsp_rdata),
    .rdata_o     (rdata_w)
  );

  assign req_valid = busy_w;
  assign req_xop   = desc_out.xop;
  assign req_read  = desc_out.is_read;
  assign req_sid   = desc_out.sid;
  assign req_addr  = desc_out.addr;
  assign req_bcm1  = desc_out.bcm1;
  assign req_wdata = desc_out.wdata;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CMD) reg_rdata = cmd_q;
    if (reg_addr == A_CFG) reg_rdata = cfg_q;
    if (reg_addr == A_STS) reg_rdata = 32'(status_w);
    for (int w = 0; w < WORDS; w++) begin
      if (reg_addr == A_WD0 + REG_AW'(4*w)) reg_rdata = payload_q[w*32 +: 32];
      if (reg_addr == A_RD0 + REG_AW'(4*w)) reg_rdata = rdata_w[w*32 +: 32];
    end
  end

  AST_CTRL_NO_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_xop[6]) |-> (req_addr == '0 && req_bcm1 == '0 && req_wdata == '0 && !req_read));  // R5

  AST_READ_NO_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_read) |-> (req_wdata == '0));  // R4

  AST_WR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((req_wdata & ~byte_expand(lane_mask(req_bcm1))) == '0));  // R3

endmodule

// File: tb/cmd_channel_engine_tb.sv
`timescale 1ns/1ps
module cmd_channel_engine_tb;

  typedef struct {
    logic [6:0]  xop;
    logic        rd;
    logic [3:0]  sid;
    logic [15:0] addr;
    logic [2:0]  bcm1;
    logic [63:0] wdata;
    logic [1:0]  code;
    logic [63:0] rdata;
    int          delay;
    bit          collide;
    logic [31:0] col_cmd;
    string       tag;
  } item_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        drv_we = 0;
  logic [5:0]  drv_addr = 0;
  logic [31:0] drv_wdata = 0;
  logic        col_we = 0;
  logic [31:0] col_cmd = 0;
  logic        reg_we;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        req_valid, req_read;
  logic [6:0]  req_xop;
  logic [3:0]  req_sid;
  logic [15:0] req_addr;
  logic [2:0]  req_bcm1;
  logic [63:0] req_wdata;
  logic        rsp_valid = 0;
  logic [1:0]  rsp_code = 0;
  logic [63:0] rsp_rdata = 0;

  int n_chk = 0;
  int n_err = 0;
  bit ended = 0;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  assign reg_we    = drv_we | col_we;
  assign reg_addr  = col_we ? 6'h00 : drv_addr;
  assign reg_wdata = col_we ? col_cmd : drv_wdata;

  cmd_channel_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_xop(req_xop), .req_read(req_read), .req_sid(req_sid),
    .req_addr(req_addr), .req_bcm1(req_bcm1), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cmdw(input int opc, input int sid, input int addr, input int bcm1);
    cmdw = {opc[4:0], 3'b000, sid[3:0], addr[15:0], 1'b0, bcm1[2:0]};
  endfunction

  function automatic logic [63:0] keep(input logic [63:0] d, input int bcm1);
    keep = '0;
    for (int k = 0; k <= bcm1; k++) keep[k*8 +: 8] = d[k*8 +: 8];
  endfunction

  function automatic item_t mk(input int xop, input bit rd, input int sid, input int addr,
                               input int bcm1, input logic [63:0] wd, input logic [1:0] code,
                               input logic [63:0] rdat, input int delay, input string tag);
    item_t it;
    it.xop = xop[6:0]; it.rd = rd; it.sid = sid[3:0]; it.addr = addr[15:0];
    it.bcm1 = bcm1[2:0]; it.wdata = wd; it.code = code; it.rdata = rdat;
    it.delay = delay; it.collide = 0; it.col_cmd = '0; it.tag = tag;
    return it;
  endfunction

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); drv_we = 1; drv_addr = a; drv_wdata = d;
    @(negedge clk); drv_we = 0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] v);
    drv_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_idle();
    while (req_valid) @(negedge clk);
  endtask

  task automatic expect_reg(input string req, input string what, input logic [5:0] a,
                            input logic [31:0] exp);
    logic [31:0] v;
    reg_read(a, v);
    chk(req, what, 128'(v), 128'(exp));
  endtask

  // scoreboard monitor and bus responder
  initial begin : responder
    item_t it;
    forever begin
      @(negedge clk);
      if (req_valid) begin
        if (exp_q.size() == 0) begin
          chk("R6/R8", "unexpected request", 128'(req_xop), 128'h7f);
          rsp_valid = 1; rsp_code = 0;
          @(negedge clk); rsp_valid = 0;
        end else begin
          it = exp_q.pop_front();
          repeat (it.delay) @(negedge clk);
          chk(it.tag, "descriptor",
              128'({req_xop, req_read, req_sid, req_addr, req_bcm1, req_wdata}),
              128'({it.xop, it.rd, it.sid, it.addr, it.bcm1, it.wdata}));
          rsp_valid = 1; rsp_code = it.code; rsp_rdata = it.rdata;
          if (it.collide) begin col_we = 1; col_cmd = it.col_cmd; end
          @(negedge clk);
          rsp_valid = 0; col_we = 0; rsp_rdata = '0;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    item_t it;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    expect_reg("R1", "status", 6'h08, 32'h0);
    expect_reg("R1", "rdata0", 6'h18, 32'h0);
    expect_reg("R1", "rdata1", 6'h1C, 32'h0);
    expect_reg("R1", "config", 6'h04, 32'h0);
    chk("R1", "req_valid", 128'(req_valid), 128'h0);

    // R11 config and unmapped
    reg_write(6'h04, 32'hA5A5_0001);
    expect_reg("R11", "config readback", 6'h04, 32'hA5A5_0001);
    expect_reg("R11", "unmapped", 6'h0C, 32'h0);

    // R2 R3 ext-write-long, 3 bytes
    reg_write(6'h10, 32'hDDCC_BBAA);
    reg_write(6'h14, 32'h1122_3344);
    expect_reg("R11", "payload0 readback", 6'h10, 32'hDDCC_BBAA);
    exp_q.push_back(mk(0, 0, 5, 16'h1234, 2, keep(64'h1122_3344_DDCC_BBAA, 2), 2'd0, '0, 3, "R2/R3"));
    reg_write(6'h00, cmdw(0, 5, 16'h1234, 2));
    expect_reg("R7", "status cleared while busy", 6'h08, 32'h0);
    wait_idle();
    expect_reg("R7", "status ok", 6'h08, 32'h1);
    expect_reg("R11", "command readback", 6'h00, cmdw(0, 5, 16'h1234, 2));

    // R3 R4 write 8 bytes, extreme fields
    exp_q.push_back(mk(14, 0, 15, 16'hFFFF, 7, 64'h1122_3344_DDCC_BBAA, 2'd0, '0, 1, "R3/R4"));
    reg_write(6'h00, cmdw(14, 15, 16'hFFFF, 7));
    wait_idle();
    expect_reg("R7", "status ok 8B", 6'h08, 32'h1);

    // R4 R9 read 5 bytes
    exp_q.push_back(mk(15, 1, 2, 16'h0310, 4, '0, 2'd0, 64'h8877_6655_4433_2211, 2, "R4"));
    reg_write(6'h00, cmdw(15, 2, 16'h0310, 4));
    wait_idle();
    expect_reg("R9", "rdata0 5B", 6'h18, 32'h4433_2211);
    expect_reg("R9", "rdata1 5B", 6'h1C, 32'h0000_0055);

    // R10 denied read leaves data
    exp_q.push_back(mk(1, 1, 7, 16'h0102, 7, '0, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R4"));
    reg_write(6'h00, cmdw(1, 7, 16'h0102, 7));
    wait_idle();
    expect_reg("R7", "status denied", 6'h08, 32'h5);
    expect_reg("R10", "rdata0 after deny", 6'h18, 32'h4433_2211);
    expect_reg("R10", "rdata1 after deny", 6'h1C, 32'h0000_0055);

    // R7 zero-write failure
    exp_q.push_back(mk(16, 0, 1, 16'h0000, 0, 64'hAA, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 2, "R4"));
    reg_write(6'h00, cmdw(16, 1, 0, 0));
    wait_idle();
    expect_reg("R7", "status fail", 6'h08, 32'h3);
    expect_reg("R10", "rdata0 after write", 6'h18, 32'h4433_2211);

    // R9 ext-read single byte
    exp_q.push_back(mk(13, 1, 4, 16'h00FE, 0, '0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R4"));
    reg_write(6'h00, cmdw(13, 4, 16'h00FE, 0));
    wait_idle();
    expect_reg("R9", "rdata0 1B", 6'h18, 32'h0000_00FF);
    expect_reg("R9", "rdata1 1B", 6'h1C, 32'h0);

    // R5 control command, stray fields ignored
    exp_q.push_back(mk(7'h44, 0, 3, 0, 0, '0, 2'd0, '0, 1, "R5"));
    reg_write(6'h00, cmdw(4, 3, 16'hBEEF, 5));
    wait_idle();
    expect_reg("R5", "status ctrl", 6'h08, 32'h1);

    // R6 refused opcode
    reg_write(6'h00, cmdw(9, 2, 16'h0044, 1));
    chk("R6", "no request", 128'(req_valid), 128'h0);
    expect_reg("R6", "status refused", 6'h08, 32'h3);
    repeat (3) @(negedge clk);
    chk("R6", "still no request", 128'(req_valid), 128'h0);

    // R7 bus-side drop code
    exp_q.push_back(mk(2, 0, 6, 16'h0A0B, 1, keep(64'h1122_3344_DDCC_BBAA, 1), 2'd3, '0, 1, "R4"));
    reg_write(6'h00, cmdw(2, 6, 16'h0A0B, 1));
    wait_idle();
    expect_reg("R7", "status dropped by bus", 6'h08, 32'h9);

    // R8 command mid-flight, then payload rewrite
    exp_q.push_back(mk(2, 0, 9, 16'h5566, 3, 64'hDDCC_BBAA, 2'd0, '0, 5, "R8/R3"));
    reg_write(6'h00, cmdw(2, 9, 16'h5566, 3));
    reg_write(6'h00, cmdw(15, 1, 16'h0042, 7));
    reg_write(6'h10, 32'h9999_9999);
    expect_reg("R8", "status while busy", 6'h08, 32'h0);
    wait_idle();
    expect_reg("R8", "status mid-flight drop", 6'h08, 32'h9);
    expect_reg("R11", "command not replaced", 6'h00, cmdw(2, 9, 16'h5566, 3));

    // R8 command in the completion cycle
    it = mk(14, 0, 8, 16'h7777, 0, 64'h99, 2'd0, '0, 2, "R8");
    it.collide = 1;
    it.col_cmd = cmdw(15, 1, 16'h0042, 0);
    exp_q.push_back(it);
    reg_write(6'h00, cmdw(14, 8, 16'h7777, 0));
    wait_idle();
    expect_reg("R8", "status same-cycle drop", 6'h08, 32'h9);
    repeat (3) @(negedge clk);
    chk("R8", "no launch after collision", 128'(req_valid), 128'h0);
    chk("R8", "scoreboard drained", 128'(exp_q.size()), 128'h0);

    // recovery: next command runs normally
    exp_q.push_back(mk(15, 1, 0, 16'h0001, 3, '0, 2'd0, 64'h0102_0304_0506_0708, 1, "R2"));
    reg_write(6'h00, cmdw(15, 0, 16'h0001, 3));
    expect_reg("R7", "status cleared after drop", 6'h08, 32'h0);
    wait_idle();
    expect_reg("R9", "rdata0 4B", 6'h18, 32'h0506_0708);
    expect_reg("R9", "rdata1 4B", 6'h1C, 32'h0);

    repeat (2) @(negedge clk);
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule